// File: doc/BRIEF.md
# Constant On-Time PWM Sequencer

This block is the clocked timing core of one synchronous buck channel. It turns a sampled feedback comparator flag into high-side and low-side gate enables. When the comparator shows the output at or below its threshold, the block fires a high-side pulse whose length is a one-shot count. After that pulse it holds a minimum off interval before another pulse is allowed. The switching rate therefore follows the load and the on-time scaling, with no frame clock. Regulation happens at the valley of the output ripple.

A valley over-current flag blocks every new pulse for as long as it is asserted. Adaptive dead time watches the gate-state feedback, so neither gate is enabled until the other is seen fully off for a programmable number of cycles. In power-save mode a zero-crossing indication parks the low side until the next high-side pulse. A global disable drops both enables at once and clears both one-shots.

Top module: `cot_pwm_seq`

## Requirements
- R1: While reset is asserted, both `hs_en_o` and `ls_en_o` are 0.
- R2: A high-side pulse is requested only while `fb_low_i` is 1. With `fb_low_i` held at 0, `hs_en_o` never rises and `ls_en_o` stays 1.
- R3: Every high-side pulse keeps `hs_en_o` at 1 for exactly `ton_i` clock cycles. A `ton_i` of 0 gives a 1-cycle pulse.
- R4: `ton_i` is captured when the pulse starts. A change during the pulse does not change that pulse's width.
- R5: Between a fall and the next rise of `hs_en_o` (no disable in between) there are at least `TOFF_CYC` clock cycles.
- R6: While `ocp_i` is 1, no new high-side pulse starts. After `ocp_i` returns to 0 with `fb_low_i` at 1, a pulse starts within 20 cycles.
- R7: `hs_en_o` rises only after `ls_fb_i` has been 0 for at least `DT_CYC` consecutive cycles.
- R8: `ls_en_o` rises only after `hs_fb_i` has been 0 for at least `DT_CYC` consecutive cycles.
- R9: `hs_en_o` and `ls_en_o` are never 1 in the same cycle.
- R10: In the waiting phase, if `psave_i` and `zc_i` are both 1 at a clock edge, `ls_en_o` is 0 from that edge until after the next high-side pulse. If `psave_i` is 0, `zc_i` has no effect.
- R11: While `disable_i` is 1, both enables are 0 in the same cycle and no pulse starts. Both one-shots are cleared, so after release a pulse may start within 40 cycles, without waiting out the minimum off time.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| disable_i | input | 1 | Global off; forces both enables low at once |
| fb_low_i | input | 1 | Sampled comparator: output at or below threshold |
| ton_i | input | TON_W | High-side on-time in clock cycles |
| ocp_i | input | 1 | Valley over-current flag |
| zc_i | input | 1 | Inductor current zero-crossing flag |
| psave_i | input | 1 | 1 selects power-save (pulse skipping) mode |
| hs_fb_i | input | 1 | High-side gate observed on |
| ls_fb_i | input | 1 | Low-side gate observed on |
| hs_en_o | output | 1 | High-side gate enable |
| ls_en_o | output | 1 | Low-side gate enable |

## Verification
Two blocking conditions can act in the same cycle: the over-current flag and the expiry of the minimum off timer. To provoke this, the bench raises `ocp_i` during a pulse and keeps `fb_low_i` high, so the off timer runs out while the flag is still set. The run passes only if no rise appears until the flag drops. Disable is also asserted in the middle of a pulse, while the on-time counter is still running. There the outputs must fall at once, and the restart must show that the off timer was cleared rather than left to expire.

// File: rtl/cot_pkg.sv
package cot_pkg;
    typedef enum logic [1:0] {
        S_WAIT = 2'd0,
        S_DTH  = 2'd1,
        S_ON   = 2'd2,
        S_DTL  = 2'd3
    } cot_state_e;
endpackage

// File: rtl/cot_oneshot.sv
module cot_oneshot #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr_i,
    input  logic         load_i,
    input  logic [W-1:0] val_i,
    output logic         busy_o
);
    logic [W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (clr_i)
            cnt_d = '0;
        else if (load_i)
            cnt_d = val_i;
        else if (cnt_q != '0)
            cnt_d = cnt_q - 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign busy_o = (cnt_q != '0);

    // R3
    oneshot_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && !clr_i && !load_i) |=> (cnt_q == $past(cnt_q) - 1'b1));
endmodule

// File: rtl/cot_deadtime.sv
module cot_deadtime #(
    parameter int DT_CYC = 6
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr_i,
    input  logic arm_i,
    input  logic gate_low_i,
    output logic done_o
);
    localparam int DW = $clog2(DT_CYC + 1);

    logic [DW-1:0] cnt_d, cnt_q;

    assign done_o = arm_i && gate_low_i && (cnt_q == DW'(DT_CYC - 1));

    always_comb begin
        if (clr_i || !arm_i || !gate_low_i || done_o)
            cnt_d = '0;
        else
            cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    // R7
    dt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q < DW'(DT_CYC));
endmodule

// File: rtl/cot_pwm_seq.sv
module cot_pwm_seq
    import cot_pkg::*;
#(
    parameter int TON_W    = 8,
    parameter int TOFF_CYC = 80,
    parameter int DT_CYC   = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             disable_i,
    input  logic             fb_low_i,
    input  logic [TON_W-1:0] ton_i,
    input  logic             ocp_i,
    input  logic             zc_i,
    input  logic             psave_i,
    input  logic             hs_fb_i,
    input  logic             ls_fb_i,
    output logic             hs_en_o,
    output logic             ls_en_o
);
    localparam int OFFW = $clog2(TOFF_CYC + 1);

    typedef struct packed {
        cot_state_e state;
        logic       skip;
        logic       hs;
        logic       ls;
    } seq_t;

    seq_t cur_q, nxt_d;

    logic             on_load, off_load, clr;
    logic             on_busy, off_busy;
    logic             dt_arm, dt_gate_low, dt_done;
    logic [TON_W-1:0] ton_val;

    assign ton_val     = (ton_i == '0) ? '0 : ton_i - 1'b1;
    assign dt_arm      = (cur_q.state == S_DTH) || (cur_q.state == S_DTL);
    assign dt_gate_low = (cur_q.state == S_DTH) ? !ls_fb_i : !hs_fb_i;

    always_comb begin
        nxt_d    = cur_q;
        on_load  = 1'b0;
        off_load = 1'b0;
        clr      = 1'b0;
        if (disable_i) begin
            nxt_d.state = S_DTL;
            nxt_d.skip  = 1'b0;
            clr         = 1'b1;
        end else begin
            unique case (cur_q.state)
                S_WAIT: begin
                    if (!off_busy && fb_low_i && !ocp_i) begin
                        nxt_d.state = S_DTH;
                        nxt_d.skip  = 1'b0;
                    end else if (psave_i && zc_i) begin
                        nxt_d.skip = 1'b1;
                    end
                end
                S_DTH: begin
                    if (dt_done) begin
                        nxt_d.state = S_ON;
                        on_load     = 1'b1;
                    end
                end
                S_ON: begin
                    if (!on_busy) begin
                        nxt_d.state = S_DTL;
                        off_load    = 1'b1;
                    end
                end
                S_DTL: begin
                    if (dt_done) nxt_d.state = S_WAIT;
                end
                default: nxt_d.state = S_DTL;
            endcase
        end
        nxt_d.hs = (nxt_d.state == S_ON);
        nxt_d.ls = (nxt_d.state == S_WAIT) && !nxt_d.skip;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_q.state <= S_DTL;
            cur_q.skip  <= 1'b0;
            cur_q.hs    <= 1'b0;
            cur_q.ls    <= 1'b0;
        end else begin
            cur_q <= nxt_d;
        end
    end

    cot_oneshot #(.W(TON_W)) u_on (
        .clk(clk), .rst_n(rst_n), .clr_i(clr), .load_i(on_load),
        .val_i(ton_val), .busy_o(on_busy)
    );

    cot_oneshot #(.W(OFFW)) u_off (
        .clk(clk), .rst_n(rst_n), .clr_i(clr), .load_i(off_load),
        .val_i(OFFW'(TOFF_CYC)), .busy_o(off_busy)
    );

    cot_deadtime #(.DT_CYC(DT_CYC)) u_dt (
        .clk(clk), .rst_n(rst_n), .clr_i(clr), .arm_i(dt_arm),
        .gate_low_i(dt_gate_low), .done_o(dt_done)
    );

    assign hs_en_o = cur_q.hs && !disable_i;
    assign ls_en_o = cur_q.ls && !disable_i;

    // R9
    no_overlap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(hs_en_o && ls_en_o));
    // R7
    hs_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cur_q.hs) |-> $past(!ls_fb_i));
    // R8
    ls_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cur_q.ls) |-> $past(!hs_fb_i));
    // R6
    ocp_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_q.state == S_WAIT && ocp_i) |=> (cur_q.state != S_DTH));
    // R5
    min_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_q.state == S_WAIT && off_busy) |=> (cur_q.state != S_DTH));
    // R11
    disable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        disable_i |=> (!cur_q.hs && !cur_q.ls));
    // R2
    fb_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_q.state == S_WAIT && !fb_low_i) |=> (cur_q.state != S_DTH));
endmodule

// File: tb/sim_cot_pwm_seq.sv
module sim_cot_pwm_seq;
    localparam int TON_W    = 8;
    localparam int TOFF_CYC = 80;
    localparam int DT_CYC   = 6;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic disable_i = 1'b0, fb_low_i = 1'b0, ocp_i = 1'b0, zc_i = 1'b0, psave_i = 1'b0;
    logic [TON_W-1:0] ton_i = 8'd10;
    logic hs_fb = 1'b0, ls_fb = 1'b0;
    logic hs_en_o, ls_en_o;

    int n_tests = 0, n_fail = 0;
    int rises = 0;
    int hs_low_cnt = 100000, ls_low_cnt = 0, hsfb_low_cnt = 0;
    logic hs_prev = 1'b0, ls_prev = 1'b0;
    int overlap_err = 0, gap_err = 0, dth_err = 0, dtl_err = 0;
    int cycles = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    cot_pwm_seq #(.TON_W(TON_W), .TOFF_CYC(TOFF_CYC), .DT_CYC(DT_CYC)) u0 (
        .clk(clk), .rst_n(rst_n), .disable_i(disable_i), .fb_low_i(fb_low_i),
        .ton_i(ton_i), .ocp_i(ocp_i), .zc_i(zc_i), .psave_i(psave_i),
        .hs_fb_i(hs_fb), .ls_fb_i(ls_fb), .hs_en_o(hs_en_o), .ls_en_o(ls_en_o)
    );

    // gate model: each gate follows its enable one cycle later
    always @(posedge clk) begin
        if (!rst_n) begin
            hs_fb <= 1'b0;
            ls_fb <= 1'b0;
        end else begin
            hs_fb <= hs_en_o;
            ls_fb <= ls_en_o;
        end
    end

    // monitor sampled mid-cycle
    always @(negedge clk) begin
        if (rst_n) begin
            if (hs_en_o && ls_en_o) overlap_err++;
            if (hs_en_o && !hs_prev) begin
                rises++;
                if (hs_low_cnt < TOFF_CYC) gap_err++;
                if (ls_low_cnt < DT_CYC) dth_err++;
            end
            if (ls_en_o && !ls_prev && hsfb_low_cnt < DT_CYC) dtl_err++;
            if (disable_i) hs_low_cnt = 100000;
            else if (!hs_en_o) hs_low_cnt++;
            else hs_low_cnt = 0;
            ls_low_cnt   = ls_fb ? 0 : ls_low_cnt + 1;
            hsfb_low_cnt = hs_fb ? 0 : hsfb_low_cnt + 1;
        end
        hs_prev = hs_en_o;
        ls_prev = ls_en_o;
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic wait_rise(output int waited, input int limit);
        waited = 0;
        while (!hs_en_o && waited < limit) begin
            @(negedge clk);
            waited++;
        end
    endtask

    task automatic pulse_width(input int ton, input int exp, input int chg, input string req);
        int w, waited;
        ton_i = TON_W'(ton);
        fb_low_i = 1'b1;
        wait_rise(waited, 1000);
        fb_low_i = 1'b0;
        w = 0;
        while (hs_en_o && w < 1000) begin
            w++;
            if (w == 2 && chg >= 0) ton_i = TON_W'(chg);
            @(negedge clk);
        end
        check(w == exp, req, w, exp);
        cyc(TOFF_CYC + 3 * DT_CYC + 10);
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000 && !done) begin
            done = 1'b1;
            n_tests++;
            n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        int r0, waited;
        cyc(3);
        // R1: reset state
        check(!hs_en_o && !ls_en_o, "R1", {hs_en_o, ls_en_o}, 0);
        @(negedge clk) rst_n = 1'b1;
        cyc(30);

        // R2: no pulses while comparator low, low side held on
        r0 = rises;
        cyc(300);
        check(rises == r0, "R2", rises - r0, 0);
        check(ls_en_o == 1'b1, "R2", ls_en_o, 1);

        // R3: sweep on-time
        for (int t = 1; t <= 24; t++) pulse_width(t, t, -1, "R3");
        pulse_width(0, 1, -1, "R3");
        pulse_width(255, 255, -1, "R3");

        // R4: mid-pulse change ignored
        pulse_width(30, 30, 3, "R4");
        pulse_width(5, 5, 200, "R4");

        // R5: continuous demand, spacing checked by monitor
        ton_i = 8'd12;
        fb_low_i = 1'b1;
        r0 = rises;
        cyc(10 * (TOFF_CYC + 12 + 3 * DT_CYC));
        check(rises - r0 >= 5, "R5", rises - r0, 5);
        check(gap_err == 0, "R5", gap_err, 0);

        // R6: over-current held across off-timer expiry
        @(negedge clk);
        wait_rise(waited, 1000);
        ocp_i = 1'b1;
        cyc(TOFF_CYC + 40);
        r0 = rises;
        cyc(300);
        check(rises == r0, "R6", rises - r0, 0);
        ocp_i = 1'b0;
        wait_rise(waited, 100);
        check(waited <= 20, "R6", waited, 20);
        fb_low_i = 1'b0;
        cyc(TOFF_CYC + 3 * DT_CYC + 300);

        // R10: zero-cross ignored without power-save
        psave_i = 1'b0;
        zc_i = 1'b1;
        cyc(5);
        check(ls_en_o == 1'b1, "R10", ls_en_o, 1);
        zc_i = 1'b0;
        psave_i = 1'b1;
        cyc(2);
        zc_i = 1'b1;
        @(negedge clk);
        zc_i = 1'b0;
        check(ls_en_o == 1'b0, "R10", ls_en_o, 0);
        cyc(20);
        check(ls_en_o == 1'b0, "R10", ls_en_o, 0);
        pulse_width(8, 8, -1, "R3");
        check(ls_en_o == 1'b1, "R10", ls_en_o, 1);
        psave_i = 1'b0;

        // R11: disable mid-pulse
        ton_i = 8'd100;
        fb_low_i = 1'b1;
        wait_rise(waited, 1000);
        cyc(5);
        disable_i = 1'b1;
        #1;
        check(!hs_en_o && !ls_en_o, "R11", {hs_en_o, ls_en_o}, 0);
        r0 = rises;
        cyc(20);
        check(rises == r0 && !ls_en_o, "R11", rises - r0, 0);
        disable_i = 1'b0;
        wait_rise(waited, 200);
        check(waited <= 40, "R11", waited, 40);
        fb_low_i = 1'b0;
        cyc(200);

        // R7 R8 R9: gate interlock across all runs
        check(dth_err == 0, "R7", dth_err, 0);
        check(dtl_err == 0, "R8", dtl_err, 0);
        check(overlap_err == 0, "R9", overlap_err, 0);

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule